// File: doc/BRIEF.md
# Indexed Pixel Palette Expander

The block reads a frame of 8-bit colour indices from a frame memory and turns each one into a direct-colour output pixel. It looks the index up in three 256-entry tables of 8 bits each, one for red, one for green and one for blue. Source lines sit at a fixed pitch of 1024 bytes in the frame memory, however many pixels are active on a line. Active width and height are run-time values and can be at most 1024 pixels by 768 lines.

A start pulse captures the depth code, the width and the height. The block then walks the frame in raster order. Each pixel leaves as one beat on a valid/ready stream. A byte count tells how many low byte lanes of the beat carry data. Start-of-line and end-of-frame flags mark the beat they belong to. The frame-memory read port and the palette read port behave as synchronous RAMs with a read enable. When the enable is low, the RAM output keeps its last value. Back-pressure on the output therefore freezes every pipeline stage together.

Top module: `pix_palette_expander`

## Requirements
- R1: After reset, `busy_o`, `out_valid_o`, `mem_rd_o` and `pal_rd_o` are low.
- R2: A start pulse does nothing when `depth_i` is 0 or when width or height is 0. In that case `busy_o` stays low and no memory read or output beat occurs.
- R3: The pixel at column x of line y is read from frame address y*1024+x. Pixels are read and emitted in raster order, using the width and height captured at start.
- R4: With `depth_i` equal to 32, each beat carries blue in bits 7:0, green in bits 15:8, red in bits 23:16 and zero in bits 31:24. `out_bytes_o` is 4.
- R5: With `depth_i` equal to 24, each beat carries blue, green and red in bits 7:0, 15:8 and 23:16, with bits 31:24 zero. `out_bytes_o` is 3.
- R6: Any other nonzero `depth_i` passes the raw index through in bits 7:0, with bits 31:8 zero. `out_bytes_o` is 1.
- R7: `out_sol_o` is high exactly on the first beat of each line. `out_eof_o` is high exactly on the last beat of the last line.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the beat and its flags stay unchanged. No beat is lost and none is repeated.
- R9: `mem_rd_o` and `pal_rd_o` are low in every cycle where a held beat is not accepted.
- R10: With `out_ready_i` held high, the first beat becomes valid on the third rising edge after the edge that captures start. After that, one beat follows per cycle.
- R11: Start is ignored while `busy_o` is high. `busy_o` falls right after the end-of-frame beat is accepted.
- R12: After start has been captured, changes on `depth_i`, `width_i` and `height_i` have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start pulse |
| depth_i | input | 6 | Output depth code (32, 24, 0, other) |
| width_i | input | 11 | Active pixels per line |
| height_i | input | 10 | Active lines per frame |
| busy_o | output | 1 | Frame in progress |
| mem_rd_o | output | 1 | Frame memory read enable |
| mem_addr_o | output | 20 | Frame memory byte address |
| mem_data_i | input | 8 | Frame memory data, one cycle after the read |
| pal_rd_o | output | 1 | Palette read enable |
| pal_idx_o | output | 8 | Palette index |
| pal_red_i | input | 8 | Red table data, one cycle after the read |
| pal_green_i | input | 8 | Green table data, one cycle after the read |
| pal_blue_i | input | 8 | Blue table data, one cycle after the read |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Output beat accepted |
| out_data_o | output | 32 | Pixel byte lanes |
| out_bytes_o | output | 3 | Number of valid low byte lanes |
| out_sol_o | output | 1 | First pixel of a line |
| out_eof_o | output | 1 | Last pixel of the frame |

## Verification
Start is captured on one edge. The memory read happens on the next edge, the palette read on the edge after that, and the output register loads on the third edge. The bench therefore expects the first beat three edges after the capturing edge and counts negative edges to confirm this. It drives `out_ready_i` at a falling edge and then samples the outputs a moment later. A beat counts as transferred only when valid and ready are both seen at that point. Read enables are checked in the same sample, because they follow ready within the cycle. `busy_o` is checked one falling edge after the end-of-frame transfer.

// File: rtl/pix_exp_pkg.sv
package pix_exp_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_IDX  = 2'd1,
    MODE_BGR  = 2'd2,
    MODE_BGRX = 2'd3
  } pix_mode_e;

  localparam int unsigned DEPTH_W = 6;

  function automatic pix_mode_e decode_depth(input logic [DEPTH_W-1:0] d);
    case (d)
      6'd0:    return MODE_OFF;
      6'd24:   return MODE_BGR;
      6'd32:   return MODE_BGRX;
      default: return MODE_IDX;
    endcase
  endfunction
endpackage

// File: rtl/pix_fetch_gen.sv
module pix_fetch_gen #(
  parameter int unsigned MAX_W  = 1024,
  parameter int unsigned MAX_H  = 768,
  parameter int unsigned STRIDE = 1024,
  localparam int unsigned XW = $clog2(MAX_W + 1),
  localparam int unsigned YW = $clog2(MAX_H + 1),
  localparam int unsigned AW = $clog2(STRIDE * MAX_H)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [XW-1:0] width_i,
  input  logic [YW-1:0] height_i,
  input  logic          step_i,
  output logic          active_o,
  output logic [AW-1:0] addr_o,
  output logic          sol_o,
  output logic          eof_o
);
  logic [XW-1:0] x_q, w_q;
  logic [YW-1:0] y_q, h_q;
  logic          active_q;
  logic          last_x, last_y;

  assign last_x = (x_q == w_q - XW'(1));
  assign last_y = (y_q == h_q - YW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q      <= '0;
      y_q      <= '0;
      w_q      <= '0;
      h_q      <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      x_q      <= '0;
      y_q      <= '0;
      w_q      <= width_i;
      h_q      <= height_i;
      active_q <= 1'b1;
    end else if (step_i && active_q) begin
      if (last_x) begin
        x_q <= '0;
        if (last_y) active_q <= 1'b0;
        else        y_q      <= y_q + YW'(1);
      end else begin
        x_q <= x_q + XW'(1);
      end
    end
  end

  // fixed pitch: line start does not depend on active width
  assign addr_o   = AW'(y_q) * AW'(STRIDE) + AW'(x_q);
  assign active_o = active_q;
  assign sol_o    = (x_q == '0);
  assign eof_o    = last_x && last_y;
endmodule

// File: rtl/pix_format.sv
module pix_format
  import pix_exp_pkg::*;
(
  input  pix_mode_e   mode_i,
  input  logic [7:0]  idx_i,
  input  logic [7:0]  red_i,
  input  logic [7:0]  green_i,
  input  logic [7:0]  blue_i,
  output logic [31:0] data_o,
  output logic [2:0]  bytes_o
);
  always_comb begin
    case (mode_i)
      MODE_BGRX: begin
        data_o  = {8'h00, red_i, green_i, blue_i};
        bytes_o = 3'd4;
      end
      MODE_BGR: begin
        data_o  = {8'h00, red_i, green_i, blue_i};
        bytes_o = 3'd3;
      end
      default: begin
        data_o  = {24'h0, idx_i};
        bytes_o = 3'd1;
      end
    endcase
  end
endmodule

// File: rtl/pix_palette_expander.sv
module pix_palette_expander
  import pix_exp_pkg::*;
#(
  parameter int unsigned MAX_W  = 1024,
  parameter int unsigned MAX_H  = 768,
  parameter int unsigned STRIDE = 1024,
  localparam int unsigned XW = $clog2(MAX_W + 1),
  localparam int unsigned YW = $clog2(MAX_H + 1),
  localparam int unsigned AW = $clog2(STRIDE * MAX_H)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [XW-1:0]      width_i,
  input  logic [YW-1:0]      height_i,
  output logic               busy_o,
  output logic               mem_rd_o,
  output logic [AW-1:0]      mem_addr_o,
  input  logic [7:0]         mem_data_i,
  output logic               pal_rd_o,
  output logic [7:0]         pal_idx_o,
  input  logic [7:0]         pal_red_i,
  input  logic [7:0]         pal_green_i,
  input  logic [7:0]         pal_blue_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [31:0]        out_data_o,
  output logic [2:0]         out_bytes_o,
  output logic               out_sol_o,
  output logic               out_eof_o
);
  pix_mode_e   mode_q;
  logic        adv, load, fetch;
  logic        f_active, f_sol, f_eof;
  logic        s1_vld_q, s1_sol_q, s1_eof_q;
  logic        s2_vld_q, s2_sol_q, s2_eof_q;
  logic [7:0]  s2_idx_q;
  logic [31:0] fmt_data;
  logic [2:0]  fmt_bytes;

  assign busy_o = f_active | s1_vld_q | s2_vld_q | out_valid_o;
  assign load   = start_i && !busy_o && (decode_depth(depth_i) != MODE_OFF)
                  && (width_i != '0) && (height_i != '0);
  // single advance enable: every stage and both RAM reads move together
  assign adv    = !out_valid_o || out_ready_i;
  assign fetch  = adv && f_active;

  pix_fetch_gen #(.MAX_W(MAX_W), .MAX_H(MAX_H), .STRIDE(STRIDE)) i_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .width_i  (width_i),
    .height_i (height_i),
    .step_i   (adv),
    .active_o (f_active),
    .addr_o   (mem_addr_o),
    .sol_o    (f_sol),
    .eof_o    (f_eof)
  );

  assign mem_rd_o  = fetch;
  assign pal_rd_o  = adv && s1_vld_q;
  assign pal_idx_o = mem_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else if (load) mode_q <= decode_depth(depth_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0; s1_sol_q <= 1'b0; s1_eof_q <= 1'b0;
      s2_vld_q <= 1'b0; s2_sol_q <= 1'b0; s2_eof_q <= 1'b0;
      s2_idx_q <= '0;
    end else if (adv) begin
      s1_vld_q <= fetch;
      s1_sol_q <= f_sol;
      s1_eof_q <= f_eof;
      s2_vld_q <= s1_vld_q;
      s2_sol_q <= s1_sol_q;
      s2_eof_q <= s1_eof_q;
      s2_idx_q <= mem_data_i;
    end
  end

  pix_format i_format (
    .mode_i  (mode_q),
    .idx_i   (s2_idx_q),
    .red_i   (pal_red_i),
    .green_i (pal_green_i),
    .blue_i  (pal_blue_i),
    .data_o  (fmt_data),
    .bytes_o (fmt_bytes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_bytes_o <= '0;
      out_sol_o   <= 1'b0;
      out_eof_o   <= 1'b0;
    end else if (adv) begin
      out_valid_o <= s2_vld_q;
      out_data_o  <= fmt_data;
      out_bytes_o <= fmt_bytes;
      out_sol_o   <= s2_sol_q && s2_vld_q;
      out_eof_o   <= s2_eof_q && s2_vld_q;
    end
  end
endmodule

// File: rtl/pix_palette_expander_chk.sv
module pix_palette_expander_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        mem_rd_o,
  input logic        pal_rd_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_data_o,
  input logic [2:0]  out_bytes_o,
  input logic        out_sol_o,
  input logic        out_eof_o
);
  AST_HOLD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o); // R8
  AST_HOLD_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_data_o) && $stable(out_bytes_o)
      && $stable(out_sol_o) && $stable(out_eof_o)); // R8
  AST_READ_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !mem_rd_o && !pal_rd_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o && !pal_rd_o && !out_valid_o); // R2
  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o[31:24] == 8'h00); // R4
  AST_IDX_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_bytes_o == 3'd1 |-> out_data_o[31:8] == 24'h0); // R6
  AST_BYTES_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_bytes_o == 3'd1 || out_bytes_o == 3'd3 || out_bytes_o == 3'd4); // R5
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(out_valid_o && out_ready_i && out_eof_o)); // R11
endmodule

bind pix_palette_expander pix_palette_expander_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .mem_rd_o    (mem_rd_o),
  .pal_rd_o    (pal_rd_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_bytes_o (out_bytes_o),
  .out_sol_o   (out_sol_o),
  .out_eof_o   (out_eof_o)
);

// File: tb/test_pix_palette_expander.sv
module test_pix_palette_expander;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  depth_i = '0;
  logic [10:0] width_i = '0;
  logic [9:0]  height_i = '0;
  logic        busy_o, mem_rd_o, pal_rd_o;
  logic [19:0] mem_addr_o;
  logic [7:0]  mem_data_i = '0;
  logic [7:0]  pal_idx_o;
  logic [7:0]  pal_red_i = '0, pal_green_i = '0, pal_blue_i = '0;
  logic        out_valid_o, out_ready_i = 1'b0;
  logic [31:0] out_data_o;
  logic [2:0]  out_bytes_o;
  logic        out_sol_o, out_eof_o;

  int checks = 0;
  int errors = 0;
  int salt = 0;
  logic [7:0] tab_r [256];
  logic [7:0] tab_g [256];
  logic [7:0] tab_b [256];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  pix_palette_expander i_pix_palette_expander (.*);

  function automatic logic [7:0] fmem(input int a);
    int v;
    v = (a * 37) ^ ((a >> 10) * 11) ^ salt;
    return v[7:0];
  endfunction

  always_ff @(posedge clk_i) begin
    if (mem_rd_o) mem_data_i <= fmem(int'(mem_addr_o));
    if (pal_rd_o) begin
      pal_red_i   <= tab_r[pal_idx_o];
      pal_green_i <= tab_g[pal_idx_o];
      pal_blue_i  <= tab_b[pal_idx_o];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(input int d);
    if (d == 32) return "R4";
    if (d == 24) return "R5";
    return "R6";
  endfunction

  // pct: percent of cycles with ready high; disturb: restart and input changes mid-frame
  task automatic run_frame(input int d, input int w, input int h, input int pct, input bit disturb);
    int k, cyc, first, last, limit, x, y;
    logic [7:0]  idx;
    logic [31:0] ed;
    int          eb;
    salt++;
    @(negedge clk_i);
    depth_i = 6'(d); width_i = 11'(w); height_i = 10'(h); start_i = 1'b1;
    k = 0; cyc = 0; first = -1; last = -1; limit = w * h * 30 + 60;
    while (k < w * h && cyc < limit) begin
      @(negedge clk_i);
      cyc++;
      start_i = 1'b0;
      if (disturb && cyc == 2) begin
        depth_i = (d == 32) ? 6'd8 : 6'd32; width_i = 11'd3; height_i = 10'd1; // R12
      end
      if (disturb && cyc == 6) start_i = 1'b1; // R11 restart while busy
      out_ready_i = (int'($urandom % 100) < pct);
      #1;
      if (out_valid_o && !out_ready_i)
        chk(!mem_rd_o && !pal_rd_o, "R9", "read during stall", {mem_rd_o, pal_rd_o}, 0);
      if (out_valid_o && out_ready_i) begin
        x = k % w; y = k / w;
        idx = fmem(y * 1024 + x); // R3 fixed 1024-byte pitch
        if (d == 32 || d == 24) ed = {8'h0, tab_r[idx], tab_g[idx], tab_b[idx]};
        else ed = {24'h0, idx};
        eb = (d == 32) ? 4 : (d == 24) ? 3 : 1;
        chk(out_data_o == ed, mode_req(d), "data", out_data_o, ed);
        chk(int'(out_bytes_o) == eb, mode_req(d), "bytes", out_bytes_o, eb);
        chk(out_sol_o == (x == 0) && out_eof_o == (k == w * h - 1), "R7", "markers",
            {out_sol_o, out_eof_o}, {(x == 0), (k == w * h - 1)});
        if (k == 0) first = cyc;
        last = cyc;
        k++;
      end
    end
    chk(k == w * h, "R8", "beat count", k, w * h);
    if (pct == 100) begin
      chk(first == 4, "R10", "first beat latency", first, 4);
      chk(last == 3 + w * h, "R10", "back-to-back beats", last, 3 + w * h);
    end
    out_ready_i = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !out_valid_o, "R11", "busy after eof", {busy_o, out_valid_o}, 0);
  endtask

  task automatic idle_start(input int d, input int w, input int h);
    bit seen = 0;
    @(negedge clk_i);
    depth_i = 6'(d); width_i = 11'(w); height_i = 10'(h); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (busy_o || mem_rd_o || out_valid_o) seen = 1;
    end
    chk(!seen, "R2", "start ignored", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      tab_r[i] = 8'($urandom); tab_g[i] = 8'($urandom); tab_b[i] = 8'($urandom);
    end
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !out_valid_o && !mem_rd_o && !pal_rd_o, "R1", "reset state",
        {busy_o, out_valid_o, mem_rd_o, pal_rd_o}, 0);
    rst_ni = 1'b1;
    idle_start(0, 8, 4);         // R2 depth zero
    idle_start(32, 0, 4);        // R2 zero width
    run_frame(32, 5, 3, 100, 0); // R4 R10
    run_frame(24, 7, 2, 100, 0); // R5
    run_frame(8, 4, 4, 100, 0);  // R6
    run_frame(5, 3, 3, 60, 0);   // R6 unknown depth
    run_frame(32, 1, 1, 100, 0); // single pixel
    run_frame(24, 6, 4, 50, 1);  // R11 R12
    run_frame(32, 1024, 2, 100, 0); // R3 full width
    run_frame(8, 1, 768, 100, 0);   // R3 last line
    for (int i = 0; i < 8; i++) begin
      int dsel = int'($urandom % 4);
      run_frame(dsel == 0 ? 32 : dsel == 1 ? 24 : dsel == 2 ? 8 : 17,
                1 + int'($urandom % 40), 1 + int'($urandom % 6),
                30 + int'($urandom % 71), 0); // R8
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule